// File: doc/BRIEF.md
# Variable-Resolution SAR Conversion Engine

This block sequences a successive-approximation conversion for a converter of up to 10 bits. A start pulse, accepted while the engine is idle, opens a conversion. The engine then spends one enabled clock sampling the input. On each of the following enabled clocks it decides one bit, beginning at the most significant bit. During each decision it presents a trial code to an external DAC and comparator and reads back a single bit. That bit is 1 when the input is at or above the trial code.

A 3-bit resolution select is captured at start. Value s gives 10 - s result bits and takes 11 - s enabled clocks. So 0 means 10 bits in 11 clocks, and 7 means 3 bits in 4 clocks. The result is left-aligned: the valid bits sit at the top of the 10-bit field and the bits below them read as zero. The engine moves only on cycles where the clock enable from an outside divider is high. A synchronous abort drops it back to idle.

Top module: `sar_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), busy, done, result and trial are all 0.
- R2: start high while idle and abort low makes busy 1 after the next clock edge. start while busy has no effect on the conversion in progress.
- R3: A conversion ends after exactly 11 - s enabled clocks, where s is res_sel sampled in the start cycle. Changes to res_sel during a conversion are ignored.
- R4: While busy, a cycle with ce low and abort low leaves busy, trial and result unchanged.
- R5: For an input x (0..1023) and a comparator that answers 1 when trial <= x, the result equals x with its lowest s bits cleared. An input of 0 gives 0, and at s = 0 an input of 1023 gives 0x3FF.
- R6: The lowest s bits of result are zero after every conversion.
- R7: done is high for exactly one cycle. In that cycle busy is 0 and result already holds the new value. result changes in no other cycle.
- R8: abort high while busy makes busy 0 after the next edge, with no done pulse and result unchanged. abort and start together while idle leave the engine idle.
- R9: The trial code is 0 when the engine is idle and in the sampling clock. While bit k is being decided, trial holds the bits already decided above k, bit k set to 1, and zeros below k. Bits are decided from bit 9 downward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Conversion clock enable from an outside divider |
| start | input | 1 | Start request, taken only while idle |
| abort | input | 1 | Synchronous return to idle with no done pulse |
| res_sel | input | 3 | Resolution select s: 10 - s bits in 11 - s enabled clocks |
| cmp | input | 1 | Comparator bit, 1 when the input is at or above trial |
| trial | output | 10 | Trial code to the DAC |
| result | output | 10 | Left-aligned result, with the unused low bits zero |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Conversion in progress |

## Verification
The hardest cases to reach are the ones where a request arrives at an awkward moment. These are an abort or a changed res_sel in the middle of a conversion, a start while the engine is busy, and an abort that lands on the same cycle as an enabled clock or a start. The stimulus holds a sample steady and runs conversions at every resolution under three ce patterns: every cycle, every third cycle, and random. Between conversions it injects these requests on chosen cycles. A behavioural model counts enabled clocks and predicts the trial code and the masked result, and every cycle is compared against it.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W    = 10,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic            start,
  input  logic            abort,
  input  logic [SELW-1:0] res_sel,
  input  logic            cmp,
  output logic [W-1:0]    trial,
  output logic [W-1:0]    result,
  output logic            done,
  output logic            busy
);
  localparam int PW = $clog2(W);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic            smp;
  logic [PW-1:0]   pos;
  logic [SELW-1:0] stop;
  logic [W-1:0]    acc;
  logic [W-1:0]    bitmask;
  logic            last;

  assign bitmask = ONE << pos;
  assign last    = (pos == PW'(stop));
  assign trial   = (busy && !smp) ? (acc | bitmask) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      smp    <= 1'b0;
      pos    <= '0;
      stop   <= '0;
      acc    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start && !abort) begin
          busy <= 1'b1;
          smp  <= 1'b1;
          acc  <= '0;
          pos  <= PW'(W - 1);
          stop <= res_sel;
        end
      end else if (abort) begin
        busy <= 1'b0;
        smp  <= 1'b0;
      end else if (ce) begin
        if (smp) begin
          smp <= 1'b0;
        end else begin
          if (cmp) acc <= acc | bitmask;
          if (last) begin
            result <= cmp ? (acc | bitmask) : acc;
            done   <= 1'b1;
            busy   <= 1'b0;
          end else begin
            pos <= pos - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sar_seq_checks.sv
module sar_seq_checks #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ce,
  input logic         start,
  input logic         abort,
  input logic [W-1:0] trial,
  input logic [W-1:0] result,
  input logic         done,
  input logic         busy
);
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !abort) |=> busy); // R2
  AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ce && !abort) |=> ($stable(trial) && busy && $stable(result))); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> (!busy && !done)); // R8
  AST_TRIAL_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (trial == '0)); // R9
endmodule

bind sar_seq sar_seq_checks #(.W(W)) u_checks (
  .clk(clk), .rst_n(rst_n), .ce(ce), .start(start), .abort(abort),
  .trial(trial), .result(result), .done(done), .busy(busy)
);

// File: tb/sar_seq_bench.sv
`timescale 1ns/1ps
module sar_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, start = 1'b0, abort = 1'b0;
  logic [2:0] res_sel = 3'd0;
  logic [9:0] sample_v = 10'd0;
  logic cmp;
  logic [9:0] trial, result;
  logic done, busy;

  int n_run = 0, n_fail = 0;
  int ce_mode = 0;
  int ce_phase = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign cmp = (trial <= sample_v);

  sar_seq u_sar_seq (
    .clk(clk), .rst_n(rst_n), .ce(ce), .start(start), .abort(abort),
    .res_sel(res_sel), .cmp(cmp), .trial(trial), .result(result),
    .done(done), .busy(busy)
  );

  int m_busy = 0, m_cnt = 0, m_total = 0, m_done = 0, m_res = 0, m_samp = 0, m_n = 10;

  function automatic int top_mask(int k);
    if (k <= 0) return 0;
    return ((1 << k) - 1) << (10 - k);
  endfunction

  always @(posedge clk) begin
    m_done = 0;
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_res = 0;
    end else if (m_busy == 0) begin
      if (start && !abort) begin
        m_busy = 1; m_cnt = 0; m_n = 10 - int'(res_sel);
        m_total = m_n + 1; m_samp = int'(sample_v);
      end
    end else if (abort) begin
      m_busy = 0;
    end else if (ce) begin
      m_cnt++;
      if (m_cnt == m_total) begin
        m_busy = 0; m_done = 1;
        m_res = m_samp & top_mask(m_n);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    case (ce_mode)
      0: ce <= 1'b1;
      1: begin ce <= (ce_phase == 0); ce_phase <= (ce_phase + 1) % 3; end
      2: ce <= 1'($urandom_range(0, 1));
      default: ce <= 1'b0;
    endcase
    if (rst_n && !finished) begin
      chk("R3 busy", int'(busy), m_busy);
      chk("R7 done", int'(done), m_done);
      chk("R5 result", int'(result), m_res);
      if (m_busy && m_cnt >= 1)
        chk("R9 trial", int'(trial), (m_samp & top_mask(m_cnt - 1)) | (1 << (10 - m_cnt)));
      else
        chk("R9 trial zero", int'(trial), 0);
    end
  end

  task automatic kick(int smp, int sel);
    sample_v = 10'(smp);
    res_sel  = 3'(sel);
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done && cyc < 150000);
  endtask

  task automatic convert(int smp, int sel);
    int low;
    kick(smp, sel);
    wait_done();
    low = (1 << sel) - 1;
    chk("R6 low bits zero", int'(result) & low, 0);
    chk("R5 masked result", int'(result), smp & ~low & 10'h3FF);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 result", int'(result), 0);
    chk("R1 trial", int'(trial), 0);
    rst_n = 1'b1;
    @(negedge clk);

    ce_mode = 0;
    convert(0, 0);
    chk("R5 zero input", int'(result), 0);
    convert(1023, 0);
    chk("R5 full scale", int'(result), 10'h3FF);
    convert(512, 0);
    convert(511, 0);
    for (int s = 0; s < 8; s++) convert(int'($urandom_range(0, 1023)), s);

    begin : latency
      int t;
      kick(700, 3);
      t = 1;
      while (!done) begin @(negedge clk); t++; end
      chk("R3 clocks for sel 3", t, 9);
    end
    @(negedge clk);

    ce_mode = 1;
    for (int s = 0; s < 8; s++) convert(int'($urandom_range(0, 1023)), 7 - s);
    ce_mode = 2;
    for (int k = 0; k < 24; k++) convert(int'($urandom_range(0, 1023)), int'($urandom_range(0, 7)));

    ce_mode = 0;
    kick(333, 0);
    repeat (3) @(negedge clk);
    res_sel = 3'd7;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R2 R3 start and sel ignored while busy", int'(result), 333);
    @(negedge clk);

    kick(800, 0);
    repeat (4) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R8 idle after abort", int'(busy), 0);
    chk("R8 result kept", int'(result), 333);
    repeat (3) @(negedge clk);
    chk("R8 no done after abort", int'(done), 0);

    abort = 1'b1;
    kick(100, 0);
    abort = 1'b0;
    chk("R8 abort with start stays idle", int'(busy), 0);

    ce_mode = 3;
    kick(600, 2);
    repeat (6) @(negedge clk);
    chk("R4 waits without ce", int'(busy), 1);
    ce_mode = 0;
    wait_done();
    chk("R4 completes after ce", int'(result), 600 & 10'h3FC);
    @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule